// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit processor bus with a 16-bit address and an external ROM and RAM. Processor writes into the lower half of the address space never reach the ROM. They program four control fields instead:

- a RAM enable flag,
- a five-bit ROM bank number,
- a two-bit shared selector,
- a banking mode bit.

The block turns every processor address into a physical ROM address and a physical RAM address. It gates the RAM write strobe and steers read data back to the processor.

The two-bit selector has two uses, chosen by the mode bit. With mode clear it widens the ROM bank number to seven bits. With mode set it picks one of four 8 KiB RAM banks. A bank number of zero written to the ROM bank field is stored as one, so the switchable window never shows the fixed bank through that field. Both physical addresses pass through size masks supplied as configuration inputs, so smaller devices simply wrap.

Top module: `bank_ctrl`

## Requirements
- R1: A register write is any `cpu_wr` with `cpu_addr[15]` = 0. The target is chosen only by `cpu_addr[14:13]`: 00 RAM enable, 01 ROM bank, 10 two-bit selector, 11 mode. The remaining address bits are ignored.
- R2: A write to the RAM enable region sets the flag when `(cpu_wdata & 8'h0A) == 8'h0A`. Any other value clears it.
- R3: A write to the ROM bank region stores `cpu_wdata[4:0]`, except that a value of 0 is stored as 1.
- R4: A write to the mode region stores `cpu_wdata[0]` as the mode bit.
- R5: With mode 0, a read in 0x4000–0x7FFF gives `rom_addr = {selector, bank, cpu_addr[13:0]}`. A RAM-window access gives `ram_addr = {2'b00, cpu_addr[12:0]}`.
- R6: With mode 1, the selector is dropped from ROM address bits 20:19, which read as 0. `ram_addr = {selector, cpu_addr[12:0]}`.
- R7: `rom_addr` is ANDed with `cfg_rom_mask` and `ram_addr` with `cfg_ram_mask`.
- R8: `ram_we` is high only for a write in 0xA000–0xBFFF while RAM is enabled and `cfg_ram_present` is 1.
- R9: An access in 0x0000–0x3FFF gives `rom_addr = cpu_addr[13:0]` with all bank bits 0, in both modes.
- R10: After reset, RAM enable is 0, the ROM bank is 1, the selector is 0 and the mode is 0.
- R11: When RAM is disabled or absent, a RAM-window read returns 8'hFF on `cpu_rdata`. When RAM is enabled and present, `cpu_rdata` carries `ram_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_wr | input | 1 | Processor write strobe |
| cfg_rom_mask | input | 21 | Mask for the physical ROM address |
| cfg_ram_mask | input | 15 | Mask for the physical RAM address |
| cfg_ram_present | input | 1 | External RAM is fitted |
| rom_rdata | input | 8 | Data from the ROM |
| ram_rdata | input | 8 | Data from the RAM |
| rom_addr | output | 21 | Physical ROM address |
| ram_addr | output | 15 | Physical RAM address |
| ram_we | output | 1 | Gated RAM write strobe |
| ram_cs | output | 1 | RAM select for the window, when enabled and present |
| cpu_rdata | output | 8 | Read data returned to the processor |

## Verification
The assertions assume that `cpu_wr` is a one-cycle strobe, with the address and data steady across the clock edge that captures it. They also assume that the mask and presence inputs are static, apart from changes made between accesses. The bench changes inputs only on the falling edge and holds each write for exactly one rising edge. It changes the configuration only while the strobe is low. It samples the combinational outputs one nanosecond after driving the inputs, so each check sees settled values.

// File: rtl/bank_ctrl.sv
module bank_ctrl #(
  parameter int BANK_W = 5,
  parameter int SEL_W = 2,
  localparam int ROM_AW = 14 + BANK_W + SEL_W,
  localparam int RAM_AW = 13 + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic [ROM_AW-1:0] cfg_rom_mask,
  input  logic [RAM_AW-1:0] cfg_ram_mask,
  input  logic              cfg_ram_present,
  input  logic [7:0]        rom_rdata,
  input  logic [7:0]        ram_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic              ram_cs,
  output logic [7:0]        cpu_rdata
);

  logic              ram_on_q;
  logic [BANK_W-1:0] bank_q;
  logic [SEL_W-1:0]  sel_q;
  logic              mode_q;

  wire ctl_wr  = cpu_wr && !cpu_addr[15];
  wire rom_win = !cpu_addr[15];
  wire fix_win = cpu_addr[15:14] == 2'b00;
  wire ram_win = cpu_addr[15:13] == 3'b101;

  wire [BANK_W-1:0] bank_in = cpu_wdata[BANK_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_on_q <= 1'b0;
      bank_q   <= BANK_W'(1);
      sel_q    <= '0;
      mode_q   <= 1'b0;
    end else if (ctl_wr) begin
      case (cpu_addr[14:13])
        2'b00: ram_on_q <= (cpu_wdata & 8'h0A) == 8'h0A;
        2'b01: bank_q   <= (bank_in == '0) ? BANK_W'(1) : bank_in;
        2'b10: sel_q    <= cpu_wdata[SEL_W-1:0];
        default: mode_q <= cpu_wdata[0];
      endcase
    end
  end

  wire [SEL_W-1:0]  rom_hi  = mode_q ? '0 : sel_q;
  wire [SEL_W-1:0]  ram_hi  = mode_q ? sel_q : '0;
  wire [ROM_AW-1:0] rom_raw = fix_win ? {{(BANK_W+SEL_W){1'b0}}, cpu_addr[13:0]}
                                      : {rom_hi, bank_q, cpu_addr[13:0]};

  assign rom_addr  = rom_raw & cfg_rom_mask;
  assign ram_addr  = {ram_hi, cpu_addr[12:0]} & cfg_ram_mask;
  assign ram_cs    = ram_win && ram_on_q && cfg_ram_present;
  assign ram_we    = ram_cs && cpu_wr;
  assign cpu_rdata = rom_win ? rom_rdata : (ram_cs ? ram_rdata : 8'hFF);

  // R2
  p_enable_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b000) |=>
      ram_on_q == (($past(cpu_wdata) & 8'h0A) == 8'h0A));

  // R3
  p_bank_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b001 && $past(rst_n)) |=> bank_q != '0);

  // R4
  p_mode_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b011) |=> mode_q == $past(cpu_wdata[0]));

  // R1
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && !cpu_addr[15]) |=> $stable({ram_on_q, bank_q, sel_q, mode_q}));

  // R8
  p_we_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_wr && cfg_ram_present && ram_on_q && cpu_addr[15:13] == 3'b101));

  // R9
  p_fixed_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fix_win |-> rom_addr[ROM_AW-1:14] == '0);

  // R11
  p_closed_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_win && !ram_on_q) |-> cpu_rdata == 8'hFF);

endmodule

// File: tb/test_bank_ctrl.sv
module test_bank_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic        cpu_wr = 0;
  logic [20:0] cfg_rom_mask = 21'h1FFFFF;
  logic [14:0] cfg_ram_mask = 15'h7FFF;
  logic        cfg_ram_present = 1;
  logic [7:0]  rom_rdata = 8'hC3;
  logic [7:0]  ram_rdata = 8'h5A;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic        ram_we, ram_cs;
  logic [7:0]  cpu_rdata;
  int checks = 0, fails = 0;
  logic we_seen;

  always #2 clk = ~clk;

  bank_ctrl i_bank_ctrl (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    #1 we_seen = ram_we;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic look(logic [15:0] a);
    @(negedge clk);
    cpu_addr = a;
    #1;
  endtask

  task automatic t_reset;
    look(16'h4000); chk("R10 bank 1 after reset", rom_addr, 21'h04000);
    look(16'hA000); chk("R10 ram off after reset", cpu_rdata, 8'hFF);
    chk("R11 closed read", ram_cs, 0);
    look(16'hA123); chk("R10 mode0 ram addr", ram_addr, 15'h0123);
  endtask

  task automatic t_enable;
    wr(16'h0000, 8'h0A); look(16'hA000); chk("R2 0x0A enables", cpu_rdata, 8'h5A);
    wr(16'h1FFF, 8'h08); look(16'hA000); chk("R1 R2 alias 0x08 disables", cpu_rdata, 8'hFF);
    wr(16'h0100, 8'hFE); look(16'hA000); chk("R2 0xFE enables", cpu_rdata, 8'h5A);
    wr(16'h0000, 8'h02); look(16'hA000); chk("R2 0x02 disables", cpu_rdata, 8'hFF);
  endtask

  task automatic t_bank;
    wr(16'h2000, 8'h00); look(16'h4000); chk("R3 zero stored as one", rom_addr, 21'h04000);
    wr(16'h3FFF, 8'h1F); look(16'h4000); chk("R1 R3 bank 31 via alias", rom_addr, 21'h7C000);
    wr(16'h2000, 8'hE3); look(16'h4000); chk("R3 low five bits", rom_addr, 21'h0C000);
    wr(16'h2000, 8'h20); look(16'h4000); chk("R3 masked zero becomes one", rom_addr, 21'h04000);
    look(16'h0000); chk("R9 rom read data", cpu_rdata, 8'hC3);
  endtask

  task automatic t_modes;
    wr(16'h2000, 8'h05); wr(16'h4000, 8'hFE);
    look(16'h4123); chk("R5 mode0 rom", rom_addr, (21'd2 << 19) | (21'd5 << 14) | 21'h0123);
    look(16'hA123); chk("R5 mode0 ram", ram_addr, 15'h0123);
    look(16'h2345); chk("R9 low window mode0", rom_addr, 21'h02345);
    wr(16'h6000, 8'h03);
    look(16'h4123); chk("R4 R6 mode1 rom", rom_addr, (21'd5 << 14) | 21'h0123);
    look(16'hA123); chk("R6 mode1 ram", ram_addr, (15'd2 << 13) | 15'h0123);
    look(16'h3000); chk("R9 low window mode1", rom_addr, 21'h03000);
    wr(16'h7FFF, 8'h02);
    look(16'hA123); chk("R4 mode cleared", ram_addr, 15'h0123);
    look(16'h7FFF); chk("R4 mode0 rom again", rom_addr, (21'd2 << 19) | (21'd5 << 14) | 21'h3FFF);
  endtask

  task automatic t_mask;
    @(negedge clk); cfg_rom_mask = 21'h1FFFF; cfg_ram_mask = 15'h1FFF;
    look(16'h4123); chk("R7 rom wrap", rom_addr, ((21'd2 << 19) | (21'd5 << 14) | 21'h0123) & 21'h1FFFF);
    wr(16'h6000, 8'h01);
    look(16'hA123); chk("R7 ram wrap", ram_addr, 15'h0123);
    @(negedge clk); cfg_rom_mask = 21'h1FFFFF; cfg_ram_mask = 15'h7FFF;
  endtask

  task automatic t_we;
    wr(16'h0000, 8'h0A);
    wr(16'hA010, 8'h11); chk("R8 enabled write", we_seen, 1);
    wr(16'hC000, 8'h11); chk("R8 outside window", we_seen, 0);
    wr(16'h0000, 8'h0A); chk("R8 register write", we_seen, 0);
    @(negedge clk); cfg_ram_present = 0;
    wr(16'hB000, 8'h11); chk("R8 absent ram", we_seen, 0);
    look(16'hB000); chk("R11 absent read", cpu_rdata, 8'hFF);
    @(negedge clk); cfg_ram_present = 1;
    wr(16'h0000, 8'h00);
    wr(16'hBFFF, 8'h11); chk("R8 disabled write", we_seen, 0);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_enable();
    t_bank();
    t_modes();
    t_mask();
    t_we();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule